// File: doc/BRIEF.md
# Peripheral Operational State Controller

This block holds the operational state of a serial peripheral and tells software when a state change has finished. Software picks one of three states: reset, run or pause. It does this by writing a two-bit code through a simple write strobe. Each accepted change drops a valid flag for a fixed settle time and raises it again when the new state takes effect. Writes made while the flag is low are discarded. Leaving pause for reset is guarded: a direct request is refused, and software must write the clear code twice in a row.

The block drives the enables the data path depends on. The shift enable is active only in run. FIFO access is allowed in run and in pause. A one-cycle flush pulse marks every completed entry into reset. A software-reset register returns all state and configuration to defaults at once. A small configuration register holds a serial-mode select and a clock auto-gating enable. The block turns that enable into a permission output that says when the clock may safely be gated.

Top module: `opstate_ctrl`

## Requirements
- R1: Address 0 reads the state word: bits 1:0 hold the current state code (0 reset, 1 run, 3 pause), bit 2 holds the valid flag, and all other bits are 0. After reset it reads 0x4.
- R2: An accepted state write clears valid on the next clock edge. Valid stays low for exactly SETTLE cycles (4 by default). It then rises, and in the same cycle bits 1:0 take the requested code.
- R3: A write to address 0 while valid is low is ignored and leaves the transition in progress unchanged.
- R4: Outside pause, writing code 2 is ignored: valid stays high and the state is unchanged.
- R5: In pause, writing code 0 is ignored. The first write of code 2 only arms the clear sequence and leaves valid high. A second consecutive write of code 2 starts a transition to reset.
- R6: After the clear sequence is armed, any other write to address 0 cancels it. Codes 1 and 3 are still carried out as normal transitions. Writes to other addresses do not cancel it.
- R7: flush_o pulses for one cycle when a transition into reset completes, and in the cycle after a software reset.
- R8: shift_en_o is high only when valid is high and the state is run. fifo_en_o is high only when valid is high and the state is run or pause.
- R9: A write to address 2 with bit 0 set returns the block to defaults on the next edge: state reset, valid high, configuration cleared, any transition or armed sequence dropped. A write to address 2 with bit 0 clear has no effect.
- R10: Address 1 is the configuration register. Bit 8 is the serial-mode select, driven on spi_mode_o. Bit 13 is the clock auto-gating enable. All other bits are not stored and read 0.
- R11: gate_ok_o is high when auto-gating is enabled, valid is high and the state is not run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, data returned the next cycle |
| addr | input | AW | Register word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered |
| state_o | output | 2 | Current state code |
| valid_o | output | 1 | High when no transition is in progress |
| shift_en_o | output | 1 | Serial shifter may advance |
| fifo_en_o | output | 1 | FIFO access allowed |
| flush_o | output | 1 | One-cycle flush of FIFOs, counters and flags |
| spi_mode_o | output | 1 | Serial-mode select from configuration |
| gate_ok_o | output | 1 | Clock may be gated |

## Verification
Every code from 0 to 3 is written from each of the three stable states. This shows which pairs are true transitions (valid drops for exactly the settle time, and a flush appears only on entry to reset) and which are refused (valid never drops). Short write sequences from pause show three cases apart: a completed double clear, a clear cancelled by another state write, and a clear left armed across a configuration write. Further cases cover a write issued during the settle window, and a software reset issued after configuration and a state change. The enable and gating outputs are sampled in each stable state and during a transition.

// File: rtl/opstate_ctrl.sv
module opstate_ctrl #(
  parameter int DW     = 32,
  parameter int AW     = 2,
  parameter int SETTLE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [1:0]    state_o,
  output logic          valid_o,
  output logic          shift_en_o,
  output logic          fifo_en_o,
  output logic          flush_o,
  output logic          spi_mode_o,
  output logic          gate_ok_o
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [1:0] ST_RST = 2'd0, ST_RUN = 2'd1, ST_CLR = 2'd2, ST_PAU = 2'd3;
  localparam logic [AW-1:0] A_ST = AW'(0), A_CFG = AW'(1), A_SR = AW'(2);
  localparam int B_SPI = 8, B_AG = 13;

  logic [1:0]    cur, tgt;
  logic          valid, armed, flush, cfg_spi, cfg_ag;
  logic [CW-1:0] cnt;

  wire [1:0] code   = wdata[1:0];
  wire       wr_st  = wr_en && addr == A_ST;
  wire       wr_cfg = wr_en && addr == A_CFG;
  wire       wr_sr  = wr_en && addr == A_SR && wdata[0];
  wire       take   = wr_st && valid && code != ST_CLR && !(cur == ST_PAU && code == ST_RST);
  wire       fire   = wr_st && valid && armed && code == ST_CLR;

  always_ff @(posedge clk) begin
    if (!rst_n || wr_sr) begin
      cur     <= ST_RST;
      tgt     <= ST_RST;
      valid   <= 1'b1;
      armed   <= 1'b0;
      cnt     <= '0;
      cfg_spi <= 1'b0;
      cfg_ag  <= 1'b0;
      flush   <= rst_n;
    end else begin
      flush <= 1'b0;
      if (!valid) begin
        if (cnt == '0) begin
          valid <= 1'b1;
          cur   <= tgt;
          flush <= tgt == ST_RST;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (take || fire) begin
        valid <= 1'b0;
        cnt   <= CW'(SETTLE - 1);
        tgt   <= fire ? ST_RST : code;
        armed <= 1'b0;
      end else if (wr_st) begin
        armed <= cur == ST_PAU && code == ST_CLR;
      end
      if (wr_cfg) begin
        cfg_spi <= wdata[B_SPI];
        cfg_ag  <= wdata[B_AG];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      case (addr)
        A_ST:    rdata[2:0] <= {valid, cur};
        A_CFG:   begin
                   rdata[B_SPI] <= cfg_spi;
                   rdata[B_AG]  <= cfg_ag;
                 end
        default: rdata <= '0;
      endcase
    end
  end

  assign state_o    = cur;
  assign valid_o    = valid;
  assign shift_en_o = valid && cur == ST_RUN;
  assign fifo_en_o  = valid && (cur == ST_RUN || cur == ST_PAU);
  assign flush_o    = flush;
  assign spi_mode_o = cfg_spi;
  assign gate_ok_o  = cfg_ag && valid && cur != ST_RUN;
endmodule

// File: rtl/opstate_ctrl_chk.sv
module opstate_ctrl_chk #(
  parameter int DW     = 32,
  parameter int AW     = 2,
  parameter int SETTLE = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [1:0]    state_o,
  input logic          valid_o,
  input logic          shift_en_o,
  input logic          fifo_en_o,
  input logic          flush_o,
  input logic          spi_mode_o,
  input logic          gate_ok_o
);
  localparam int LW = $clog2(SETTLE + 2);
  logic [LW-1:0] low;
  wire st_wr = wr_en && addr == AW'(0);
  wire sr_wr = wr_en && addr == AW'(2) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n || valid_o) low <= '0;
    else if (low != LW'(SETTLE + 1)) low <= low + 1'b1;
  end

  p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> low < LW'(SETTLE));
  p_rise_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid_o) && !$past(sr_wr)) |-> $past(low) == LW'(SETTLE - 1));
  p_state_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != $past(state_o) && !$past(sr_wr)) |-> $rose(valid_o));
  p_clr_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && st_wr && !sr_wr && wdata[1:0] == 2'd2 && state_o != 2'd3) |=> valid_o);
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (state_o == 2'd0 && valid_o));
  p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_o |-> (fifo_en_o && valid_o));
  p_srst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr |=> (state_o == 2'd0 && valid_o && !spi_mode_o && !gate_ok_o && flush_o));
  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gate_ok_o |-> (!shift_en_o && valid_o));
endmodule

bind opstate_ctrl opstate_ctrl_chk #(.DW(DW), .AW(AW), .SETTLE(SETTLE)) u_chk (.*);

// File: tb/sim_opstate_ctrl.sv
module sim_opstate_ctrl;
  localparam int SETTLE = 4;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0] state_o;
  logic valid_o, shift_en_o, fifo_en_o, flush_o, spi_mode_o, gate_ok_o;
  int total = 0, fails = 0;

  opstate_ctrl #(.DW(32), .AW(2), .SETTLE(SETTLE)) u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic settle(output int n, output bit fl);
    n = 0; fl = 0;
    while (!valid_o && n < 20) begin
      @(negedge clk); n++;
      if (flush_o) fl = 1;
    end
  endtask

  task automatic go(input logic [1:0] c);
    int n; bit fl;
    wr(0, {30'd0, c}); settle(n, fl);
  endtask

  task automatic home();
    wr(2, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n; bit fl;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, d); chk("R1 reset word", d, 32'h4);
    chk("R8 reset enables", {shift_en_o, fifo_en_o}, 0);

    for (int fi = 0; fi < 3; fi++) begin
      for (int c = 0; c < 4; c++) begin
        logic [1:0] f;
        bit acc;
        logic [1:0] es;
        f = (fi == 2) ? 2'd3 : 2'(fi);
        home();
        if (f == 2'd3) go(1);
        if (f != 2'd0) go(f);
        acc = (c != 2) && !(f == 2'd3 && c == 0);
        es = acc ? 2'(c) : f;
        wr(0, 32'(c));
        if (acc) begin
          chk("R2 valid drops", valid_o, 0);
          chk("R8 enables low while busy", {shift_en_o, fifo_en_o}, 0);
          settle(n, fl);
          chk("R2 settle length", n, SETTLE);
          chk("R7 flush on reset entry", fl, (c == 0));
        end else begin
          chk((c == 2) ? "R4 code 2 refused" : "R5 direct reset from pause refused", valid_o, 1);
        end
        rd(0, d); chk("R1 state word after sweep", d, 32'h4 | es);
      end
    end

    home(); go(1); go(3);
    chk("R8 pause enables", {shift_en_o, fifo_en_o}, 2'b01);
    wr(0, 2); chk("R5 first clear arms only", valid_o, 1);
    wr(0, 2); chk("R5 second clear starts", valid_o, 0);
    settle(n, fl); chk("R5 clear settle", n, SETTLE);
    chk("R5 reached reset", state_o, 0); chk("R7 flush after clear", fl, 1);

    home(); go(1); go(3); wr(0, 2); wr(0, 1); settle(n, fl);
    chk("R6 cancel then run", state_o, 1);
    chk("R8 run enables", {shift_en_o, fifo_en_o}, 2'b11);

    home(); go(1); go(3); wr(0, 2); wr(0, 0); wr(0, 2);
    chk("R6 cancelled clear re-arms only", valid_o, 1);
    chk("R6 still pause", state_o, 3);

    home(); go(1); go(3); wr(0, 2); wr(1, 32'h100); wr(0, 2);
    chk("R6 config write keeps arm", valid_o, 0);
    settle(n, fl); chk("R6 reset after split clear", state_o, 0);

    home(); wr(0, 1); wr(0, 3); settle(n, fl);
    chk("R3 busy write ignored", state_o, 1);

    wr(1, 32'hFFFF_FFFF); rd(1, d);
    chk("R10 config readback", d, 32'h2100);
    chk("R10 spi mode out", spi_mode_o, 1);
    chk("R11 gate blocked in run", gate_ok_o, 0);
    wr(0, 3); chk("R11 gate blocked while busy", gate_ok_o, 0);
    settle(n, fl); chk("R11 gate in pause", gate_ok_o, 1);

    wr(2, 32'h0); rd(0, d); chk("R9 bit0 clear no effect", d, 32'h7);
    @(negedge clk); wr_en = 1; addr = 2; wdata = 1;
    @(negedge clk); wr_en = 0;
    chk("R9 soft reset flush", flush_o, 1);
    chk("R9 soft reset state", {valid_o, state_o}, 3'b100);
    chk("R9 spi mode cleared", spi_mode_o, 0);
    rd(1, d); chk("R9 config cleared", d, 0);
    wr(1, 32'h2000);
    chk("R11 gate in reset", gate_ok_o, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule